// File: doc/BRIEF.md
# Pipeline Hazard Stall and Bypass Controller

This block is the hazard-control logic for a five-stage integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. Decoded register numbers and control bits arrive from the pipeline registers. The block compares the source registers of the instructions in decode and execute against the destinations of the instructions in execute, memory and writeback. From that comparison it produces three kinds of output. The bypass selects choose what feeds the two ALU operands. The hold signals freeze the program counter and the fetch/decode register. The flush signals turn the fetch/decode and decode/execute registers into bubbles.

A compile-time parameter picks one of two variants. In the bypass variant, results are routed from memory or writeback straight to the ALU operands. A stall is then needed only when a load in execute feeds an instruction in decode. In the bubble-only variant, the operand selects stay on the register file. Any read of a register that execute or memory is about to write holds decode until the producer reaches writeback, where a write-before-read register file serves the value. In both variants, a taken branch or jump resolved in execute squashes the two younger instructions. A jump-and-link counts as writing the all-ones register, whatever its destination field holds.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: In bypass mode, an operand select is 2'b10 (memory result) when the memory-stage instruction writes a nonzero register equal to that operand's execute-stage source.
- R2: Otherwise, in bypass mode, the select is 2'b01 (writeback result) when the writeback-stage instruction writes a nonzero register equal to the source, and 2'b00 (register file) in every other case; 2'b11 never appears.
- R3: Register 0 is never bypassed and never causes a hold, even when a stage claims to write it.
- R4: In bypass mode, a load in execute whose nonzero destination equals a used decode source raises pc_hold and ifid_hold and sets idex_flush for that cycle.
- R5: In bypass mode, a non-load producer in execute or any producer in memory causes no hold.
- R6: In bubble-only mode, both selects stay at 2'b00. A used decode source that matches a nonzero register written in execute or memory holds decode and flushes decode/execute, while a match only in writeback does not.
- R7: When a stage's link flag is set, its destination is taken as the all-ones register number and its destination field is ignored.
- R8: When redirect is high, ifid_flush and idex_flush are both high and pc_hold and ifid_hold are both low, whatever data hazard is present.
- R9: A decode source whose use flag is low never causes a hold.
- R10: Over a short sequence, a dependent ALU pair costs 0 hold cycles in bypass mode and 2 in bubble-only mode. A load followed by a dependent use costs 1 and 2. A taken branch flushes 2 instruction slots in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | RW | First source register of the decode-stage instruction |
| id_rt | input | RW | Second source register of the decode-stage instruction |
| id_rs_use | input | 1 | Decode instruction actually reads id_rs |
| id_rt_use | input | 1 | Decode instruction actually reads id_rt |
| ex_rs | input | RW | First source register of the execute-stage instruction |
| ex_rt | input | RW | Second source register of the execute-stage instruction |
| ex_dst | input | RW | Destination field of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_link | input | 1 | Execute-stage instruction is a jump-and-link |
| mem_dst | input | RW | Destination field of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_link | input | 1 | Memory-stage instruction is a jump-and-link |
| wb_dst | input | RW | Destination field of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| wb_link | input | 1 | Writeback-stage instruction is a jump-and-link |
| redirect | input | 1 | Taken branch or jump resolved in execute |
| op_a_sel | output | 2 | First ALU operand source: 00 register file, 01 writeback, 10 memory |
| op_b_sel | output | 2 | Second ALU operand source, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Replace the fetch/decode contents with a bubble |
| idex_flush | output | 1 | Replace the decode/execute contents with a bubble |

## Verification
The two functions that can land in the same cycle are a data-hazard stall and a redirect squash. This happens when a load or producer sits in execute ahead of a dependent decode instruction while that same execute instruction is also a taken branch. The pseudo-random sweep drives redirect together with every hazard pattern. The bench expects the redirect to win, with both flushes high and both holds low. The short pipeline sequences then count hold cycles and flushed slots. Those counts are compared with the arithmetic cost of each hazard in each mode.

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int RW  = 5,
  parameter bit FWD = 1'b1
) (
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic          id_rs_use,
  input  logic          id_rt_use,
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic          ex_link,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_link,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  input  logic          wb_link,
  input  logic          redirect,
  output logic [1:0]    op_a_sel,
  output logic [1:0]    op_b_sel,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_flush,
  output logic          idex_flush
);

  localparam logic [RW-1:0] LINK_REG = '1;
  localparam logic [RW-1:0] ZERO_REG = '0;
  localparam logic [1:0]    SEL_RF   = 2'b00;
  localparam logic [1:0]    SEL_WB   = 2'b01;
  localparam logic [1:0]    SEL_MEM  = 2'b10;

  logic [RW-1:0] ex_w, mem_w, wb_w;
  logic          ex_live, mem_live, wb_live;
  logic          rs_hit_ex, rt_hit_ex, rs_hit_mem, rt_hit_mem;
  logic          data_stall;

  assign ex_w  = ex_link  ? LINK_REG : ex_dst;
  assign mem_w = mem_link ? LINK_REG : mem_dst;
  assign wb_w  = wb_link  ? LINK_REG : wb_dst;

  assign ex_live  = ex_wr  && (ex_w  != ZERO_REG);
  assign mem_live = mem_wr && (mem_w != ZERO_REG);
  assign wb_live  = wb_wr  && (wb_w  != ZERO_REG);

  assign rs_hit_ex  = id_rs_use && ex_live  && (id_rs == ex_w);
  assign rt_hit_ex  = id_rt_use && ex_live  && (id_rt == ex_w);
  assign rs_hit_mem = id_rs_use && mem_live && (id_rs == mem_w);
  assign rt_hit_mem = id_rt_use && mem_live && (id_rt == mem_w);

  generate
    if (FWD) begin : g_bypass
      function automatic logic [1:0] pick(input logic [RW-1:0] src,
                                          input logic            ml,
                                          input logic [RW-1:0] md,
                                          input logic            wl,
                                          input logic [RW-1:0] wd);
        if (ml && src == md)      return SEL_MEM;
        else if (wl && src == wd) return SEL_WB;
        else                      return SEL_RF;
      endfunction

      assign op_a_sel   = pick(ex_rs, mem_live, mem_w, wb_live, wb_w);
      assign op_b_sel   = pick(ex_rt, mem_live, mem_w, wb_live, wb_w);
      assign data_stall = ex_load && (rs_hit_ex || rt_hit_ex);
    end else begin : g_bubble
      logic unused_bypass;
      assign unused_bypass = ^{ex_rs, ex_rt, ex_load, wb_live};
      assign op_a_sel   = SEL_RF;
      assign op_b_sel   = SEL_RF;
      assign data_stall = rs_hit_ex || rt_hit_ex || rs_hit_mem || rt_hit_mem;
    end
  endgenerate

  assign pc_hold    = data_stall && !redirect;
  assign ifid_hold  = data_stall && !redirect;
  assign ifid_flush = redirect;
  assign idex_flush = data_stall || redirect;

endmodule

module pipe_hazard_ctl_chk #(
  parameter int RW  = 5,
  parameter bit FWD = 1'b1
) (
  input logic [RW-1:0] ex_rs,
  input logic [RW-1:0] ex_rt,
  input logic          ex_load,
  input logic          id_rs_use,
  input logic          id_rt_use,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wr,
  input logic          mem_link,
  input logic          wb_wr,
  input logic          redirect,
  input logic [1:0]    op_a_sel,
  input logic [1:0]    op_b_sel,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          ifid_flush,
  input logic          idex_flush
);
  logic [RW-1:0] mem_target;
  assign mem_target = mem_link ? {RW{1'b1}} : mem_dst;

  always_comb begin
    if (!$isunknown({ex_rs, ex_rt, ex_load, id_rs_use, id_rt_use, mem_target,
                     mem_wr, wb_wr, redirect, op_a_sel, op_b_sel, pc_hold,
                     ifid_hold, ifid_flush, idex_flush})) begin
      // R3
      zero_src_a_chk: assert (ex_rs != '0 || op_a_sel == 2'b00);
      // R3
      zero_src_b_chk: assert (ex_rt != '0 || op_b_sel == 2'b00);
      // R2
      sel_code_chk: assert (op_a_sel != 2'b11 && op_b_sel != 2'b11);
      // R1
      mem_src_a_chk: assert (op_a_sel != 2'b10 || (mem_wr && mem_target == ex_rs));
      // R2
      wb_src_chk: assert ((op_a_sel != 2'b01 && op_b_sel != 2'b01) || wb_wr);
      // R8
      redirect_chk: assert (!redirect || (ifid_flush && idex_flush && !pc_hold && !ifid_hold));
      // R4
      hold_bubble_chk: assert (!pc_hold || (ifid_hold && idex_flush));
      // R5
      load_only_chk: assert (!(FWD && pc_hold) || ex_load);
      // R6
      bubble_rf_chk: assert (FWD || (op_a_sel == 2'b00 && op_b_sel == 2'b00));
      // R9
      unused_src_chk: assert (!pc_hold || id_rs_use || id_rt_use);
    end
  end
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.RW(RW), .FWD(FWD)) u_chk (
  .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_load(ex_load),
  .id_rs_use(id_rs_use), .id_rt_use(id_rt_use),
  .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_link(mem_link),
  .wb_wr(wb_wr), .redirect(redirect),
  .op_a_sel(op_a_sel), .op_b_sel(op_b_sel), .pc_hold(pc_hold),
  .ifid_hold(ifid_hold), .ifid_flush(ifid_flush), .idex_flush(idex_flush)
);

// File: tb/pipe_hazard_ctl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctl_tb;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [RW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic id_rs_use, id_rt_use, ex_wr, ex_load, ex_link, mem_wr, mem_link;
  logic wb_wr, wb_link, redirect;

  logic [1:0] fa, fb, ba, bb;
  logic fph, fih, fif, fxf, bph, bih, bif, bxf;

  pipe_hazard_ctl #(.RW(RW), .FWD(1'b1)) u_dut (
    .id_rs, .id_rt, .id_rs_use, .id_rt_use, .ex_rs, .ex_rt, .ex_dst,
    .ex_wr, .ex_load, .ex_link, .mem_dst, .mem_wr, .mem_link, .wb_dst,
    .wb_wr, .wb_link, .redirect,
    .op_a_sel(fa), .op_b_sel(fb), .pc_hold(fph), .ifid_hold(fih),
    .ifid_flush(fif), .idex_flush(fxf));

  pipe_hazard_ctl #(.RW(RW), .FWD(1'b0)) u_dut_bub (
    .id_rs, .id_rt, .id_rs_use, .id_rt_use, .ex_rs, .ex_rt, .ex_dst,
    .ex_wr, .ex_load, .ex_link, .mem_dst, .mem_wr, .mem_link, .wb_dst,
    .wb_wr, .wb_link, .redirect,
    .op_a_sel(ba), .op_b_sel(bb), .pc_hold(bph), .ifid_hold(bih),
    .ifid_flush(bif), .idex_flush(bxf));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] eff(input logic [RW-1:0] d, input logic l);
    return l ? {RW{1'b1}} : d;
  endfunction

  function automatic logic [1:0] exp_sel(input logic [RW-1:0] src);
    logic [RW-1:0] m, w;
    m = eff(mem_dst, mem_link);
    w = eff(wb_dst, wb_link);
    if (mem_wr && m != 0 && m == src) return 2'b10;
    if (wb_wr && w != 0 && w == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic hit(input logic [RW-1:0] s, input logic u,
                               input logic [RW-1:0] d, input logic w);
    return u && w && d != 0 && s == d;
  endfunction

  task automatic set_all(input logic [31:0] v);
    {id_rs, id_rt, id_rs_use, id_rt_use, ex_rs, ex_rt, ex_dst, ex_wr, ex_load,
     ex_link, mem_dst, mem_wr, mem_link, wb_dst, wb_wr, wb_link, redirect} = v[23:0];
  endtask

  task automatic sweep_one(input logic [31:0] v);
    logic [RW-1:0] e, m;
    logic hx, hm, fst, bst;
    set_all(v);
    #1;
    e = eff(ex_dst, ex_link);
    m = eff(mem_dst, mem_link);
    hx = hit(id_rs, id_rs_use, e, ex_wr) || hit(id_rt, id_rt_use, e, ex_wr);
    hm = hit(id_rs, id_rs_use, m, mem_wr) || hit(id_rt, id_rt_use, m, mem_wr);
    fst = ex_load && hx;
    bst = hx || hm;
    // R1 R2 R3 R7 bypass selects
    chk("R1/R2 op_a_sel", {6'd0, fa}, {6'd0, exp_sel(ex_rs)});
    chk("R1/R2 op_b_sel", {6'd0, fb}, {6'd0, exp_sel(ex_rt)});
    // R4 R5 R8 R9 bypass-mode stall and squash
    chk("R4 holds fwd", {6'd0, fph, fih}, {6'd0, {2{fst && !redirect}}});
    chk("R8 flush fwd", {6'd0, fif, fxf}, {6'd0, redirect, fst || redirect});
    // R6 bubble-only mode
    chk("R6 sel bub", {4'd0, ba, bb}, 8'd0);
    chk("R6 holds bub", {6'd0, bph, bih}, {6'd0, {2{bst && !redirect}}});
    chk("R6 flush bub", {6'd0, bif, bxf}, {6'd0, redirect, bst || redirect});
  endtask

  typedef struct packed {
    logic br, urs, urt;
    logic [RW-1:0] rs, rt, dst;
    logic wr, ld, lnk;
  } ins_t;

  localparam ins_t NOP = '0;

  task automatic drive(input ins_t i, input ins_t x, input ins_t m, input ins_t w);
    id_rs = i.rs; id_rt = i.rt; id_rs_use = i.urs; id_rt_use = i.urt;
    ex_rs = x.rs; ex_rt = x.rt; ex_dst = x.dst; ex_wr = x.wr; ex_load = x.ld;
    ex_link = x.lnk; redirect = x.br;
    mem_dst = m.dst; mem_wr = m.wr; mem_link = m.lnk;
    wb_dst = w.dst; wb_wr = w.wr; wb_link = w.lnk;
  endtask

  task automatic run(input bit fwd, input ins_t p0, input ins_t p1, input ins_t p2,
                     output int stalls, output int flushes);
    ins_t prog [4];
    ins_t si, sx, sm, sw;
    int pc;
    logic h, f1, f2;
    prog[0] = p0; prog[1] = p1; prog[2] = p2; prog[3] = NOP;
    si = prog[0]; sx = NOP; sm = NOP; sw = NOP; pc = 1;
    stalls = 0; flushes = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      drive(si, sx, sm, sw);
      #1;
      h  = fwd ? fph : bph;
      f1 = fwd ? fif : bif;
      f2 = fwd ? fxf : bxf;
      stalls += int'(h);
      flushes += int'(f1) + int'(f2 && !h);
      sw = sm; sm = sx;
      if (f1) begin
        sx = NOP; si = NOP; pc++;
      end else if (h) begin
        sx = NOP;
      end else begin
        sx = si;
        si = (pc < 4) ? prog[pc] : NOP;
        pc++;
      end
    end
  endtask

  initial begin
    int st, fl;
    ins_t alu1, alu2, ld1, br;
    set_all(32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 R3 idle state during reset
    chk("R2 reset sel", {4'd0, fa, fb}, 8'd0);
    chk("R3 reset holds", {4'd0, fph, fih, bph, bih}, 8'd0);
    chk("R8 reset flush", {4'd0, fif, fxf, bif, bxf}, 8'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 6000; i++) begin
      logic [31:0] x;
      x = (i + 1) * 32'h9E3779B1;
      x = x ^ (x >> 15);
      x = x * 32'h85EBCA77;
      x = x ^ (x >> 13);
      sweep_one(x);
    end

    // R7 link destination directed
    set_all(32'd0);
    id_rs = 2'b11; id_rs_use = 1'b1; ex_dst = 2'b00; ex_wr = 1'b1;
    ex_load = 1'b1; ex_link = 1'b1;
    #1;
    chk("R7 link hold", {6'd0, fph, bph}, 8'h03);
    // R9 unused source
    id_rs_use = 1'b0;
    #1;
    chk("R9 unused no hold", {6'd0, fph, bph}, 8'h00);
    // R3 register 0 written
    id_rs = 2'b00; id_rs_use = 1'b1; ex_link = 1'b0;
    #1;
    chk("R3 zero no hold", {6'd0, fph, bph}, 8'h00);

    alu1 = '{br:0, urs:0, urt:0, rs:0, rt:0, dst:2'd1, wr:1, ld:0, lnk:0};
    alu2 = '{br:0, urs:1, urt:0, rs:2'd1, rt:0, dst:2'd2, wr:1, ld:0, lnk:0};
    ld1  = '{br:0, urs:0, urt:0, rs:0, rt:0, dst:2'd1, wr:1, ld:1, lnk:0};
    br   = '{br:1, urs:0, urt:0, rs:0, rt:0, dst:0, wr:0, ld:0, lnk:0};

    // R10 dependent ALU pair
    run(1'b1, alu1, alu2, NOP, st, fl);
    chk("R10 alu fwd stalls", 8'(st), 8'd0);
    run(1'b0, alu1, alu2, NOP, st, fl);
    chk("R10 alu bub stalls", 8'(st), 8'd2);
    // R10 load-use
    run(1'b1, ld1, alu2, NOP, st, fl);
    chk("R10 load fwd stalls", 8'(st), 8'd1);
    run(1'b0, ld1, alu2, NOP, st, fl);
    chk("R10 load bub stalls", 8'(st), 8'd2);
    // R10 taken branch
    run(1'b1, br, alu1, alu1, st, fl);
    chk("R10 branch fwd flushed", 8'(fl), 8'd2);
    run(1'b0, br, alu1, alu1, st, fl);
    chk("R10 branch bub flushed", 8'(fl), 8'd2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule